// File: doc/BRIEF.md
# Sixteen-Channel PWM with Per-Channel Staged Duty Updates

The block drives sixteen pulse-width outputs from one free-running period counter. Each channel has two 8-bit compare positions: a rise position where its output goes high and a fall position where it goes low. Software programs the block through a plain write port made of an address, a data word and a strobe.

Each channel may be built with a staging copy of its two compare positions. The per-channel parameter `STAGED` chooses this. On a staged channel, a runtime mask bit picks one of two update modes. In held mode, new positions wait in the staging copy and move into the live pair at the next counter wrap. In direct mode, new positions apply on the next clock. Channels built without staging always update directly, so their mask bits do nothing.

Top module: `shadow_pwm`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, every bit of `pwm_o` is 0. The update mask resets to all zeros, so every channel starts in direct mode.
- R2: The shared counter resets to 0. On each clock it counts up by one until it reaches or passes the period value, and on the next clock it returns to 0. That return is the wrap event. Address 0 holds the 8-bit period, taken from `wr_data[7:0]`.
- R3: A channel output goes to 1 on the clock after the counter equals the channel's live rise position. It goes to 0 on the clock after the counter equals the live fall position. At all other times it keeps its value.
- R4: When a channel's live rise and fall positions are equal, its output goes to 0 on the next clock and stays at 0.
- R5: Address 1+2n writes the rise position of channel n, and address 2+2n writes its fall position, each from `wr_data[7:0]`. Address 33 writes the 16-bit update mask from `wr_data[15:0]`, where bit n belongs to channel n. A write to any address from 34 to 63 changes no register and no output.
- R6: On a channel built without staging (`STAGED[n]` = 0), a position write reaches the live pair on the next clock, whatever the value of mask bit n.
- R7: On a staged channel with mask bit n = 1, a position write leaves the live pair unchanged until the next wrap. At that wrap the staged values become live.
- R8: On a staged channel in held mode, a write that lands in the same cycle as a wrap waits for the following wrap. The counter therefore never works from a half-updated pair.
- R9: On a staged channel with mask bit n = 0, a position write reaches the live pair on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 16 | Write data |
| pwm_o | output | 16 | Registered PWM outputs, bit n is channel n |

## Verification
Two events can fall in the same cycle: a position write to a held-mode staged channel, and the counter wrap. The bench tracks its own copy of the counter and drives the write exactly when the next edge will be a wrap. It then compares all sixteen outputs cycle by cycle against a model in which the write waits a full extra period. Random traffic repeats the collision many times, with short periods and toggled mask bits, across both staged and unstaged channels.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_NCH = 16;
  localparam int unsigned PWM_DW  = 8;
  localparam int unsigned PWM_MW  = 16;

  // address of the rise position for channel ch; fall is one above
  function automatic int unsigned rise_addr(input int unsigned ch);
    return 1 + 2 * ch;
  endfunction
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          per_we,
  input  logic [DW-1:0] per_data,
  output logic [DW-1:0] cnt,
  output logic          wrap
);
  logic [DW-1:0] period_q;

  assign wrap = (cnt >= period_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '1;
      cnt      <= '0;
    end else begin
      if (per_we) period_q <= per_data;
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt >= period_q) |=> (cnt == '0));
  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt < period_q) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pwm_slot.sv
module pwm_slot #(
  parameter int unsigned DW         = 8,
  parameter bit          HAS_STAGE  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cnt,
  input  logic          wrap,
  input  logic          sync_en,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic [DW-1:0] wdata,
  output logic          pwm_q
);
  logic [DW-1:0] live_rise, live_fall;

  generate
    if (HAS_STAGE) begin : g_staged
      logic [DW-1:0] stg_rise, stg_fall;
      always_ff @(posedge clk) begin
        if (rst) begin
          stg_rise  <= '0;
          stg_fall  <= '0;
          live_rise <= '0;
          live_fall <= '0;
        end else begin
          if (wr_rise) stg_rise <= wdata;
          if (wr_fall) stg_fall <= wdata;
          if (sync_en) begin
            if (wrap) begin
              live_rise <= stg_rise;
              live_fall <= stg_fall;
            end
          end else begin
            if (wr_rise) live_rise <= wdata;
            if (wr_fall) live_fall <= wdata;
          end
        end
      end

      p_held_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_en && !wrap) |=> ($stable(live_rise) && $stable(live_fall)));
      p_wrap_same_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        (sync_en && wrap && wr_rise) |=> (live_rise == $past(stg_rise)));
      p_direct_r9: assert property (@(posedge clk) disable iff (rst)
        (!sync_en && wr_fall) |=> (live_fall == $past(wdata)));
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          live_rise <= '0;
          live_fall <= '0;
        end else begin
          if (wr_rise) live_rise <= wdata;
          if (wr_fall) live_fall <= wdata;
        end
      end

      p_mask_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_rise && (sync_en || wrap)) |=> (live_rise == $past(wdata)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                         pwm_q <= 1'b0;
    else if (live_rise == live_fall) pwm_q <= 1'b0;
    else if (cnt == live_fall)       pwm_q <= 1'b0;
    else if (cnt == live_rise)       pwm_q <= 1'b1;
  end

  p_equal_low_r4: assert property (@(posedge clk) disable iff (rst)
    (live_rise == live_fall) |=> !pwm_q);
  p_fall_low_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == live_fall) |=> !pwm_q);
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import pwm_pkg::*;
#(
  parameter int unsigned NCH    = PWM_NCH,
  parameter int unsigned DW     = PWM_DW,
  parameter int unsigned MW     = PWM_MW,
  parameter int unsigned AW     = 6,
  parameter logic [NCH-1:0] STAGED = 16'h0F0F
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [MW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o
);
  localparam int unsigned MASK_ADDR = 1 + 2 * NCH;

  logic [DW-1:0]  cnt;
  logic           wrap;
  logic [NCH-1:0] mask_q;

  pwm_period_ctr #(.DW(DW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .per_we   (wr_en && (wr_addr == '0)),
    .per_data (wr_data[DW-1:0]),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)                                         mask_q <= '0;
    else if (wr_en && (wr_addr == AW'(MASK_ADDR)))   mask_q <= wr_data[NCH-1:0];
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit_rise, hit_fall;
      assign hit_rise = wr_en && (wr_addr == AW'(rise_addr(i)));
      assign hit_fall = wr_en && (wr_addr == AW'(rise_addr(i) + 1));

      pwm_slot #(.DW(DW), .HAS_STAGE(STAGED[i])) u_slot (
        .clk     (clk),
        .rst     (rst),
        .cnt     (cnt),
        .wrap    (wrap),
        .sync_en (mask_q[i]),
        .wr_rise (hit_rise),
        .wr_fall (hit_fall),
        .wdata   (wr_data[DW-1:0]),
        .pwm_q   (pwm_o[i])
      );
    end
  endgenerate

  p_reset_low_r1: assert property (@(posedge clk) rst |=> (pwm_o == '0));
  p_mask_reset_r1: assert property (@(posedge clk) rst |=> (mask_q == '0));
endmodule

// File: tb/shadow_pwm_test.sv
module shadow_pwm_test;
  localparam int NCH = 16;
  localparam logic [15:0] STG = 16'h0F0F;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [5:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] pwm_o;

  int n_tests = 0, n_fail = 0;

  shadow_pwm uut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .pwm_o(pwm_o));

  always #5 clk = ~clk;

  // reference model
  logic [7:0]  m_cnt, m_per;
  logic [15:0] m_mask, m_out;
  logic [7:0]  m_rise [NCH], m_fall [NCH], m_srise [NCH], m_sfall [NCH];

  function automatic logic next_out(input logic [7:0] c, r, f, input logic prev);
    if (r == f)      return 1'b0;
    else if (c == f) return 1'b0;
    else if (c == r) return 1'b1;
    else             return prev;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_per = 8'hFF; m_mask = 0; m_out = 0;
      for (int i = 0; i < NCH; i++) begin
        m_rise[i] = 0; m_fall[i] = 0; m_srise[i] = 0; m_sfall[i] = 0;
      end
    end else begin
      logic w;
      logic [15:0] old_mask;
      w = (m_cnt >= m_per);
      old_mask = m_mask;
      for (int i = 0; i < NCH; i++)
        m_out[i] = next_out(m_cnt, m_rise[i], m_fall[i], m_out[i]);
      for (int i = 0; i < NCH; i++) begin
        logic held;
        held = STG[i] && old_mask[i];
        if (held && w) begin m_rise[i] = m_srise[i]; m_fall[i] = m_sfall[i]; end
        if (wr_en && wr_addr == 6'(1 + 2*i)) begin
          m_srise[i] = wr_data[7:0];
          if (!held) m_rise[i] = wr_data[7:0];
        end
        if (wr_en && wr_addr == 6'(2 + 2*i)) begin
          m_sfall[i] = wr_data[7:0];
          if (!held) m_fall[i] = wr_data[7:0];
        end
      end
      if (wr_en && wr_addr == 6'd33) m_mask = wr_data;
      m_cnt = w ? 8'd0 : m_cnt + 8'd1;
      if (wr_en && wr_addr == 6'd0) m_per = wr_data[7:0];
    end
  end

  task automatic check(input string tag);
    n_tests++;
    if (pwm_o !== m_out) begin
      n_fail++;
      $display("FAIL %s: pwm_o=%h expected %h", tag, pwm_o, m_out);
    end
  endtask

  // we are at a negedge: drive, let one edge pass, compare at next negedge
  task automatic cyc(input logic we, input logic [5:0] a, input logic [15:0] d,
                     input string tag);
    wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst = 0;
    @(negedge clk);
    check("R1 after release");
    if (pwm_o !== 16'h0) begin
      n_fail++; $display("FAIL R1: pwm_o=%h expected 0000", pwm_o);
    end
    n_tests++;

    // R2/R3 base waveform, R4 equal positions
    cyc(1, 0, 16'd9, "R2 period");
    cyc(1, 1, 16'd2, "R5 ch0 rise");
    cyc(1, 2, 16'd6, "R5 ch0 fall");
    cyc(1, 9, 16'd3, "R4 ch4 rise");
    cyc(1, 10, 16'd3, "R4 ch4 fall");
    cyc(1, 11, 16'd0, "R3 ch5 rise");
    cyc(1, 12, 16'd9, "R3 ch5 fall");
    idle(30, "R3/R4 waveform");

    // held mode everywhere: unstaged ch4 direct, staged ch0 held
    cyc(1, 33, 16'hFFFF, "R5 mask");
    cyc(1, 9, 16'd1, "R6 ch4 rise");
    cyc(1, 10, 16'd7, "R6 ch4 fall");
    cyc(1, 1, 16'd5, "R7 ch0 rise");
    cyc(1, 2, 16'd8, "R7 ch0 fall");
    idle(25, "R6/R7 held vs direct");

    // R8: write exactly on a wrap edge
    while (m_cnt != m_per) cyc(0, 0, 0, "R8 align");
    cyc(1, 3, 16'd4, "R8 write at wrap");
    idle(25, "R8 wait extra period");

    // R9: staged channel, mask bit cleared
    cyc(1, 33, 16'h0000, "R9 mask off");
    cyc(1, 1, 16'd1, "R9 ch0 rise");
    idle(15, "R9 direct");

    // R5: out-of-map addresses ignored
    for (int a = 34; a < 64; a++) cyc(1, 6'(a), 16'hFFFF, "R5 unmapped");
    idle(25, "R5 after unmapped");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [5:0] a;
      logic [15:0] d;
      r = $urandom_range(0, 99);
      if (r < 3)       begin a = 0;  d = 16'($urandom_range(4, 20)); end
      else if (r < 8)  begin a = 33; d = 16'($urandom); end
      else if (r < 35) begin a = 6'($urandom_range(1, 32)); d = 16'($urandom_range(0, 21)); end
      else if (r < 38) begin a = 6'($urandom_range(34, 63)); d = 16'($urandom); end
      else             begin a = 0; d = 0; end
      if (r < 38) cyc(1, a, d, "R2 random");
      else begin
        if (m_cnt == m_per) begin
          a = 6'($urandom_range(1, 8)); cyc(1, a, 16'($urandom_range(0, 21)), "R8 random collide");
        end else cyc(0, 0, 0, "R2 random idle");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule